// File: doc/BRIEF.md
# Power-Up Configuration Load Sequencer

This controller rebuilds a volatile, two-stage configuration bank from a nonvolatile image each time the supply comes up. It holds off while an undervoltage-lockout input is active. Once lockout clears, it copies the image into the front stage of the bank one word per clock. It then commits every front word to the back stage in a single cycle. It waits a fixed settling interval and finally hands the first sequencer state definition to the sequencing engine. The nonvolatile image is modelled as a computed internal array.

The `bus_busy` output tells the bus interface to answer every transaction with a not-acknowledge. It stays high until the copy and commit have finished. After a load completes, the host can apply live edits, which write both stages of one word at once. A host reload command repeats the copy and commit, which throws those edits away and brings back the programmed image. A return of lockout at any point abandons the load and starts it again once the supply is good.

Top module: `cfg_load_seq`

## Requirements
- R1: In reset and on the first cycle after it, `bus_busy` is 1, `load_done` and `seq_state_vld` are 0, and every front and back word reads 0.
- R2: While `lockout` is 1, no load starts: `bus_busy` stays 1 and every front word stays unchanged.
- R3: On the first clock edge with `lockout` at 0, the controller leaves idle. The next WORDS edges write image word i into front word i, for i = 0 first. Image word i is the low DW bits of (i × 0x01010101) XOR 0x5A3C96E1.
- R4: No back word changes while front words are being copied. On the edge after the last front write, a single commit copies all front words into all back words.
- R5: `bus_busy` is 1 from reset, from idle and from the start of a reload until the commit edge, and 0 after it.
- R6: SETTLE_CYC edges after the commit, the controller moves to the state-load step. On the edge after that, `seq_state` takes the low DW bits of SEQ_INIT and `seq_state_vld` becomes 1.
- R7: `load_done` is high for exactly one cycle, the same cycle in which `seq_state_vld` first reads 1.
- R8: If `lockout` is 1 at an edge, whatever the state, the controller goes back to idle. `bus_busy` is 1 and `seq_state_vld` is 0 after that edge. On release, the load restarts from word 0 with the timing of R3 to R6.
- R9: In the done state, `reload_req` starts a new copy on the next edge with the same timing as R3 to R6, and `seq_state_vld` drops. After the commit, every back word equals the image again.
- R10: `reload_req` has no effect while a load is in progress. The load finishes at its original cycle.
- R11: `edit_en` writes `edit_data` into both the front and back word at `edit_addr` on the next edge, but only in the done state. At any other time, including the settling wait when the bus is no longer busy, it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lockout | input | 1 | 1 while the supply is below the lockout threshold |
| reload_req | input | 1 | Host command to reload from the image |
| edit_en | input | 1 | Host live edit strobe |
| edit_addr | input | AW | Word index of the live edit |
| edit_data | input | DW | Value of the live edit |
| rd_addr | input | AW | Word index to observe |
| rd_front | output | DW | Front-stage word at rd_addr |
| rd_back | output | DW | Back-stage (active) word at rd_addr |
| bus_busy | output | 1 | 1: bus interface must not-acknowledge |
| seq_state_vld | output | 1 | First sequencer state has been loaded |
| seq_state | output | DW | First sequencer state definition |
| load_done | output | 1 | One-cycle pulse at the end of a load |

## Verification
The bench builds the block with WORDS=8, DW=16 and SETTLE_CYC=20 in place of the 50,000-cycle default. The short settle lets dozens of complete loads, reloads and lockout aborts fit in one run. Eight words keep the copy short enough that a lockout pulse can be placed on every phase of a load: copy, commit, settling wait and state fetch. The bench then compares the back stage before and after the commit edge and checks both when the bus frees and when the done pulse appears.

// File: rtl/cfg_load_pkg.sv
// Package: shared state encoding and image content function for the
// configuration load sequencer. Assumes image words fit in 32 bits.
package cfg_load_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_COPY   = 3'd1,
        ST_COMMIT = 3'd2,
        ST_SETTLE = 3'd3,
        ST_LOAD   = 3'd4,
        ST_DONE   = 3'd5
    } ld_state_e;

    // Programmed nonvolatile content for word i (caller truncates to DW)
    function automatic logic [31:0] image_word(input int unsigned i);
        return (i * 32'h0101_0101) ^ 32'h5A3C_96E1;
    endfunction

endpackage

// File: rtl/cfg_image_rom.sv
// Nonvolatile image model: WORDS configuration words plus one sequencer
// state word at index WORDS. Read is combinational. Assumes WORDS >= 2.
module cfg_image_rom #(
    parameter int unsigned WORDS    = 8,
    parameter int unsigned DW       = 16,
    parameter int unsigned SEQ_INIT = 32'h0000_1E5A,
    localparam int unsigned AW      = $clog2(WORDS)
) (
    input  logic [AW-1:0] word_addr,
    output logic [DW-1:0] word_data,
    output logic [DW-1:0] state_word
);
    import cfg_load_pkg::*;

    logic [DW-1:0] rom [WORDS];

    // Fill each image entry from the programmed content function
    for (genvar g = 0; g < WORDS; g++) begin : g_rom
        assign rom[g] = DW'(image_word(g));
    end

    // Select the configuration word being copied
    assign word_data  = rom[word_addr];
    assign state_word = DW'(SEQ_INIT);

endmodule

// File: rtl/cfg_bank.sv
// Double-staged configuration bank. Front words take copy writes; a commit
// copies every front word to its back word in one edge; a live edit writes
// both stages of one word. Assumes the controller never overlaps them.
module cfg_bank #(
    parameter int unsigned WORDS = 8,
    parameter int unsigned DW    = 16,
    localparam int unsigned AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwr_en,
    input  logic [AW-1:0] fwr_addr,
    input  logic [DW-1:0] fwr_data,
    input  logic          commit,
    input  logic          edit_en,
    input  logic [AW-1:0] edit_addr,
    input  logic [DW-1:0] edit_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_front,
    output logic [DW-1:0] rd_back
);
    logic [DW-1:0] front [WORDS];
    logic [DW-1:0] back  [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // Front stage: copy write or live edit of this word
        always_ff @(posedge clk) begin
            if (!rst_n)
                front[g] <= '0;
            else if (fwr_en && fwr_addr == AW'(g))
                front[g] <= fwr_data;
            else if (edit_en && edit_addr == AW'(g))
                front[g] <= edit_data;
        end

        // Back stage: bank-wide commit or live edit of this word
        always_ff @(posedge clk) begin
            if (!rst_n)
                back[g] <= '0;
            else if (commit)
                back[g] <= front[g];
            else if (edit_en && edit_addr == AW'(g))
                back[g] <= edit_data;
        end
    end

    // Observation port
    assign rd_front = front[rd_addr];
    assign rd_back  = back[rd_addr];

    AST_COMMIT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (!fwr_en && !edit_en)); // R4

endmodule

// File: rtl/cfg_settle_timer.sv
// Settling delay counter: counts while run is high and flags the last
// cycle of a SETTLE_CYC-cycle window. Clears whenever run is low.
// Assumes SETTLE_CYC >= 2.
module cfg_settle_timer #(
    parameter int unsigned SETTLE_CYC = 50000,
    localparam int unsigned CW        = $clog2(SETTLE_CYC)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt;

    // Advance while running, otherwise hold at zero
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt != LAST)
            cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == LAST);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST); // R6
    AST_EXPIRE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(run)); // R6

endmodule

// File: rtl/cfg_load_seq.sv
// Power-up configuration load sequencer. Waits for lockout release, copies
// the image into the front stage one word per cycle, commits all words at
// once, waits SETTLE_CYC cycles and loads the first sequencer state. Holds
// bus_busy until the commit. Assumes lockout is synchronous to clk.
module cfg_load_seq #(
    parameter int unsigned WORDS      = 8,
    parameter int unsigned DW         = 16,
    parameter int unsigned SETTLE_CYC = 50000,
    parameter int unsigned SEQ_INIT   = 32'h0000_1E5A,
    localparam int unsigned AW        = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lockout,
    input  logic          reload_req,
    input  logic          edit_en,
    input  logic [AW-1:0] edit_addr,
    input  logic [DW-1:0] edit_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_front,
    output logic [DW-1:0] rd_back,
    output logic          bus_busy,
    output logic          seq_state_vld,
    output logic [DW-1:0] seq_state,
    output logic          load_done
);
    import cfg_load_pkg::*;

    localparam logic [AW-1:0] LAST_IDX = AW'(WORDS - 1);

    ld_state_e     state;
    logic [AW-1:0] idx;
    logic [DW-1:0] img_data;
    logic [DW-1:0] img_state;
    logic          settle_done;
    logic          edit_ok;

    cfg_image_rom #(.WORDS(WORDS), .DW(DW), .SEQ_INIT(SEQ_INIT)) u_rom (
        .word_addr (idx),
        .word_data (img_data),
        .state_word(img_state)
    );

    cfg_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == ST_SETTLE),
        .expire(settle_done)
    );

    assign edit_ok = edit_en && !lockout && (state == ST_DONE);

    cfg_bank #(.WORDS(WORDS), .DW(DW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .fwr_en   (state == ST_COPY && !lockout),
        .fwr_addr (idx),
        .fwr_data (img_data),
        .commit   (state == ST_COMMIT && !lockout),
        .edit_en  (edit_ok),
        .edit_addr(edit_addr),
        .edit_data(edit_data),
        .rd_addr  (rd_addr),
        .rd_front (rd_front),
        .rd_back  (rd_back)
    );

    // Load sequence state machine with lockout override
    always_ff @(posedge clk) begin
        if (!rst_n || lockout) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    state <= ST_COPY;
                    idx   <= '0;
                end
                ST_COPY: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST_IDX)
                        state <= ST_COMMIT;
                end
                ST_COMMIT: state <= ST_SETTLE;
                ST_SETTLE: if (settle_done) state <= ST_LOAD;
                ST_LOAD:   state <= ST_DONE;
                ST_DONE: begin
                    if (reload_req) begin
                        state <= ST_COPY;
                        idx   <= '0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Sequencer state hand-off and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_state_vld <= 1'b0;
            seq_state     <= '0;
            load_done     <= 1'b0;
        end else begin
            load_done <= !lockout && (state == ST_LOAD);
            if (lockout || (state == ST_DONE && reload_req)) begin
                seq_state_vld <= 1'b0;
            end else if (state == ST_LOAD) begin
                seq_state_vld <= 1'b1;
                seq_state     <= img_state;
            end
        end
    end

    // Refuse bus traffic until the commit has happened
    assign bus_busy = (state == ST_IDLE) || (state == ST_COPY) || (state == ST_COMMIT);

    AST_LOCKOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        lockout |=> (state == ST_IDLE)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> !load_done); // R7
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |-> (!bus_busy && seq_state_vld)); // R5
    AST_RELOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COPY && !lockout && reload_req) |=>
        (state == ST_COPY || state == ST_COMMIT)); // R10
    AST_SETTLE_BEFORE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> ($past(state) == ST_SETTLE)); // R6

endmodule

// File: tb/tb_cfg_load_seq.sv
`timescale 1ns/100ps
module tb_cfg_load_seq;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int DW  = 16;
    localparam int S   = 20;
    localparam int AW  = 3;
    localparam int SEQ = 32'h0000_1E5A;
    localparam int DONE_K = W + 3 + S;

    logic clk = 0, rst_n = 0, lockout = 1, reload_req = 0, edit_en = 0;
    logic [AW-1:0] edit_addr = '0, rd_addr = '0;
    logic [DW-1:0] edit_data = '0;
    logic [DW-1:0] rd_front, rd_back, seq_state;
    logic bus_busy, seq_state_vld, load_done;

    int n_chk = 0, n_bad = 0;
    logic [DW-1:0] mback [W];

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_load_seq #(.WORDS(W), .DW(DW), .SETTLE_CYC(S), .SEQ_INIT(SEQ)) dut (
        .clk(clk), .rst_n(rst_n), .lockout(lockout), .reload_req(reload_req),
        .edit_en(edit_en), .edit_addr(edit_addr), .edit_data(edit_data),
        .rd_addr(rd_addr), .rd_front(rd_front), .rd_back(rd_back),
        .bus_busy(bus_busy), .seq_state_vld(seq_state_vld),
        .seq_state(seq_state), .load_done(load_done));

    function automatic logic [DW-1:0] img(input int i);
        return DW'((i * 32'h0101_0101) ^ 32'h5A3C_96E1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    // Compare every back word (and optionally front) to model or image
    task automatic scan(input string req, input bit back_img, input bit front_img);
        for (int a = 0; a < W; a++) begin
            rd_addr = AW'(a);
            #0.5;
            chk(rd_back == (back_img ? img(a) : mback[a]), req, rd_back,
                back_img ? img(a) : mback[a]);
            if (front_img) chk(rd_front == img(a), req, rd_front, img(a));
        end
    endtask

    // One full load; start stimulus already applied before edge 1.
    // rl_k: reload pulse injected at negedge rl_k; ed_k: edit during load.
    task automatic load_run(input int rl_k, input int ed_k);
        for (int k = 1; k <= DONE_K; k++) begin
            @(negedge clk);
            reload_req = 0;
            edit_en = 0;
            if (k == 1) chk(seq_state_vld == 0, "R9", seq_state_vld, 0);
            if (k == W + 1) begin
                chk(bus_busy == 1, "R5", bus_busy, 1);
                scan("R4", 0, 1);
            end
            if (k == W + 2) begin
                chk(bus_busy == 0, "R5", bus_busy, 0);
                scan("R4", 1, 0);
                for (int a = 0; a < W; a++) mback[a] = img(a);
            end
            if (k < DONE_K && load_done) chk(0, "R6", load_done, 0);
            if (k == DONE_K) begin
                chk(load_done == 1, "R7", load_done, 1);
                chk(seq_state_vld == 1, "R6", seq_state_vld, 1);
                chk(seq_state == DW'(SEQ), "R6", seq_state, DW'(SEQ));
            end
            if (k == rl_k) reload_req = 1;
            if (k == ed_k) begin
                edit_en = 1; edit_addr = 0; edit_data = ~img(0);
            end
        end
        @(negedge clk);
        chk(load_done == 0, "R7", load_done, 0);
        if (ed_k != 0) begin
            rd_addr = 0; #0.5;
            chk(rd_back == img(0), "R11", rd_back, img(0));
        end
    endtask

    task automatic do_edits(input int n);
        for (int e = 0; e < n; e++) begin
            logic [AW-1:0] ad;
            logic [DW-1:0] dv;
            ad = AW'($urandom_range(0, W - 1));
            dv = DW'($urandom);
            edit_en = 1; edit_addr = ad; edit_data = dv;
            @(negedge clk);
            edit_en = 0;
            mback[ad] = dv;
            rd_addr = ad; #0.5;
            chk(rd_back == dv, "R11", rd_back, dv);
            chk(rd_front == dv, "R11", rd_front, dv);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int a = 0; a < W; a++) mback[a] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(bus_busy == 1, "R1", bus_busy, 1);
        chk(load_done == 0, "R1", load_done, 0);
        chk(seq_state_vld == 0, "R1", seq_state_vld, 0);
        scan("R1", 0, 0);
        // R2 lockout held
        repeat (10) @(negedge clk);
        chk(bus_busy == 1, "R2", bus_busy, 1);
        for (int a = 0; a < W; a++) begin
            rd_addr = AW'(a); #0.5;
            chk(rd_front == 0, "R2", rd_front, 0);
        end
        // R3 first load, with an edit during the settling wait (R11)
        lockout = 0;
        load_run(0, W + 4);
        // R9 reload after edits, R10 reload pulse during copy ignored
        do_edits(6);
        reload_req = 1;
        load_run(3, 0);
        // Random rounds: edits, reload, optional lockout abort (R8)
        for (int r = 0; r < 30; r++) begin
            int gk;
            do_edits($urandom_range(1, 4));
            reload_req = 1;
            if ($urandom_range(0, 1) == 1) begin
                gk = $urandom_range(1, DONE_K - 1);
                for (int k = 1; k <= gk; k++) begin
                    @(negedge clk);
                    reload_req = 0;
                end
                if (gk >= W + 2) for (int a = 0; a < W; a++) mback[a] = img(a);
                lockout = 1;
                @(negedge clk);
                chk(bus_busy == 1, "R8", bus_busy, 1);
                chk(seq_state_vld == 0, "R8", seq_state_vld, 0);
                scan("R8", 0, 0);
                repeat ($urandom_range(1, 3)) @(negedge clk);
                chk(bus_busy == 1, "R8", bus_busy, 1);
                lockout = 0;
                // Edge 1 leaves idle, so R3 timing applies
                load_run(0, 0);
            end else begin
                load_run(($urandom_range(0, 1) == 1) ? $urandom_range(2, W + 1) : 0, 0);
            end
        end
        summary();
    end
endmodule